// File: doc/BRIEF.md
# Real-Mode Physical Address Generator with Bit-20 Gate

This block turns a 16-bit segment value and a 16-bit offset into a physical address for a processor running in the legacy real addressing mode. It keeps four segment registers: code, data, stack and extra. It picks one of them from the kind of access being made. A fetch uses the code segment, an ordinary load or store uses the data segment and a push or pop uses the stack segment. An explicit override input selects the extra segment whatever the access kind. The address is the selected segment shifted left by four bits plus the offset. That sum can reach 0x10FFEF, so it is 21 bits wide.

A compatibility gate sits after the adder. While the gate is closed, address bit 20 is forced to zero, so addresses wrap at one megabyte as they did on the earliest parts. While the gate is open, bit 20 passes through unchanged. The gate follows a single bit of a small output-port register. Software writes that register with an 8-bit data bus and a one-cycle write strobe. The gate is closed after reset.

The segment registers are loaded through their own write port. The physical address is combinational: it is formed from the stored segment values, the current offset, the access kind and the stored gate bit.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset every segment register holds zero and the gate is closed. The address output then equals the offset, zero-extended to 21 bits.
- R2: When `seg_wr_en` is high at a rising clock edge, the register named by `seg_wr_sel` (0 code, 1 data, 2 stack, 3 extra) takes `seg_wr_data`. The other three registers keep their values.
- R3: With `use_extra` low and `acc_kind` = 0 (instruction fetch), the code segment is used.
- R4: With `use_extra` low and `acc_kind` = 1 (data access), the data segment is used. The unassigned code `acc_kind` = 3 also uses the data segment.
- R5: With `use_extra` low and `acc_kind` = 2 (stack access), the stack segment is used.
- R6: With `use_extra` high, the extra segment is used for every value of `acc_kind`.
- R7: With the gate open, `phys_addr` equals the selected segment times 16 plus the offset, as a full 21-bit sum. For example, 0xFFFF:0xFFFF gives 0x10FFEF.
- R8: With the gate closed, bit 20 of `phys_addr` is zero and bits 19..0 equal those of the sum. For example, 0xFFFF:0xFFFF gives 0x0FFEF.
- R9: A write with `io_wr_stb` high sets the gate from bit 1 of `io_wr_data` (1 open, 0 closed). The other seven data bits have no effect.
- R10: The gate bit changes only at a clock edge where `io_wr_stb` is high. Changes on `io_wr_data` without the strobe leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_wr_en | input | 1 | Segment register load enable |
| seg_wr_sel | input | 2 | Segment to load: 0 code, 1 data, 2 stack, 3 extra |
| seg_wr_data | input | 16 | Value to load into the segment |
| offset | input | 16 | Offset of the current access |
| acc_kind | input | 2 | 0 fetch, 1 data, 2 stack, 3 treated as data |
| use_extra | input | 1 | Override: use the extra segment |
| io_wr_stb | input | 1 | One-cycle write strobe for the output-port register |
| io_wr_data | input | 8 | Port write data; bit 1 is the gate control |
| phys_addr | output | 21 | Physical address after the gate |

## Verification
Distinct segment values (0x1000, 0x2000, 0x3000, 0x4000) are loaded, so each access kind and the override produce an address that shows which register was picked. A repeated offset then separates selection errors from adder errors. The corner pair 0xFFFF:0xFFFF and 0xF800:0x8000 produces a carry into bit 20. These are applied with the gate closed and open, which tells a working gate apart from a stuck or inverted one. A sum below one megabyte confirms that the gate leaves the lower bits alone. Port writes of 0xFD, 0x02 and 0xFF, and data-bus changes with no strobe, tell apart a gate that decodes bit 1 alone, one that decodes any other bit, and one that updates without the strobe.

// File: rtl/seg_addr_pkg.sv
// Package seg_addr_pkg
// Shared widths and encodings for the real-mode address generator.
// Assumes: the segment shift is a whole number of bits and the offset is
// no wider than the segment plus the shift.
package seg_addr_pkg;

    parameter int SEG_W   = 16;   // segment register width
    parameter int OFF_W   = 16;   // offset width
    parameter int SHIFT   = 4;    // segment scale: times 16
    parameter int PORT_W  = 8;    // output-port data width
    parameter int GATE_IX = 1;    // port bit that opens the gate

    localparam int ADDR_W = SEG_W + SHIFT + 1;   // room for the carry
    localparam int NSEG   = 4;
    localparam int SEL_W  = $clog2(NSEG);

    // Segment register index; the write port uses the same codes
    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    // Kind of memory access; code 3 is unassigned and handled as data
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_STACK = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/seg_regfile.sv
// Module seg_regfile
// Holds the segment registers. It has one synchronous write port and one
// combinational read port. Every register clears on reset.
// Assumes: at most one register is written per cycle.
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int W = SEG_W,
    parameter int N = NSEG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_sel,
    input  logic [W-1:0]         wr_data,
    input  logic [$clog2(N)-1:0] rd_sel,
    output logic [W-1:0]         rd_data
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Load one register when selected; clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (wr_sel == g[$clog2(N)-1:0]))
                regs[g] <= wr_data;
        end
    end

    // Read-port multiplexer
    always_comb rd_data = regs[rd_sel];

endmodule

// File: rtl/gate_port.sv
// Module gate_port
// Output-port register that controls the bit-20 gate. Only the gate bit of
// a write is stored, because no other bit drives any logic.
// Assumes: io_stb is high for one cycle per write.
module gate_port
    import seg_addr_pkg::*;
#(
    parameter int PW  = PORT_W,
    parameter int BIT = GATE_IX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_stb,
    input  logic [PW-1:0] io_data,
    output logic          gate_open
);

    // Take the gate bit on a strobe; closed after reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_open <= 1'b0;
        else if (io_stb)
            gate_open <= io_data[BIT];
    end

endmodule

// File: rtl/addr_gen.sv
// Module addr_gen
// Shifts the segment, adds the offset into a result one bit wider than
// needed for the segment, and clears the top bit while the gate is closed.
// Assumes: OW <= SW + SH, so the offset fits the sum width.
module addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int OW = OFF_W,
    parameter int SH = SHIFT
) (
    input  logic [SW-1:0]    seg,
    input  logic [OW-1:0]    off,
    input  logic             gate_open,
    output logic [SW+SH:0]   addr
);

    localparam int AW = SW + SH + 1;

    logic [AW-1:0] sum;

    // Full-width sum of the scaled segment and the offset
    always_comb sum = {1'b0, seg, {SH{1'b0}}} + {{(AW-OW){1'b0}}, off};

    // Wrap gate on the top bit only
    always_comb addr = {sum[AW-1] & gate_open, sum[AW-2:0]};

endmodule

// File: rtl/seg_addr_unit.sv
// Module seg_addr_unit
// Real-mode physical address generator. It chooses a segment from the
// access kind or the extra-segment override, forms segment*16 + offset,
// and applies the bit-20 gate set through the output-port register.
// Assumes: segment loads and port writes are synchronous; the address is
// combinational from stored state and the current access inputs.
module seg_addr_unit
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        acc_kind,
    input  logic              use_extra,
    input  logic              io_wr_stb,
    input  logic [PORT_W-1:0] io_wr_data,
    output logic [ADDR_W-1:0] phys_addr
);

    logic [SEL_W-1:0] rd_sel;
    logic [SEG_W-1:0] seg_val;
    logic             gate_open;

    // Segment choice: the override wins, otherwise decode the access kind
    always_comb begin
        if (use_extra) begin
            rd_sel = SEG_EXTRA;
        end else begin
            unique case (acc_kind_e'(acc_kind))
                ACC_FETCH: rd_sel = SEG_CODE;
                ACC_STACK: rd_sel = SEG_STACK;
                default:   rd_sel = SEG_DATA;
            endcase
        end
    end

    seg_regfile #(.W(SEG_W), .N(NSEG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .rd_sel  (rd_sel),
        .rd_data (seg_val)
    );

    gate_port #(.PW(PORT_W), .BIT(GATE_IX)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_stb    (io_wr_stb),
        .io_data   (io_wr_data),
        .gate_open (gate_open)
    );

    addr_gen #(.SW(SEG_W), .OW(OFF_W), .SH(SHIFT)) u_add (
        .seg       (seg_val),
        .off       (offset),
        .gate_open (gate_open),
        .addr      (phys_addr)
    );

endmodule

// File: rtl/seg_addr_chk.sv
// Module seg_addr_chk
// Assertion checker for seg_addr_unit. It watches the port writes, the
// stored gate bit and the address output. It is attached by the bind
// statement below.
module seg_addr_chk #(
    parameter int PW = 8,
    parameter int OW = 16,
    parameter int AW = 21,
    parameter int GB = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_wr_stb,
    input logic [PW-1:0] io_wr_data,
    input logic [OW-1:0] offset,
    input logic [AW-1:0] phys_addr,
    input logic          gate_q
);

    // R8: a closed gate never lets bit 20 out
    assert_gate_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |-> !phys_addr[AW-1]);

    // R9: a strobed write loads the gate from the control bit
    assert_gate_follows_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr_stb |=> (gate_q == $past(io_wr_data[GB])));

    // R10: without a strobe the gate holds its value
    assert_gate_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr_stb |=> $stable(gate_q));

    // R7: the scaled segment has no low-nibble bits, so the offset nibble shows through
    assert_low_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[3:0] == offset[3:0]);

endmodule

bind seg_addr_unit seg_addr_chk #(
    .PW(8), .OW(16), .AW(21), .GB(1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr_stb  (io_wr_stb),
    .io_wr_data (io_wr_data),
    .offset     (offset),
    .phys_addr  (phys_addr),
    .gate_q     (gate_open)
);

// File: tb/tb_seg_addr_unit.sv
// Directed bench for seg_addr_unit. Inputs change on the falling edge and
// outputs are sampled 2 ns later. Each scenario task makes its own checks.
module tb_seg_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic [15:0] offset = '0;
    logic [1:0]  acc_kind = '0;
    logic        use_extra = 1'b0;
    logic        io_wr_stb = 1'b0;
    logic [7:0]  io_wr_data = '0;
    logic [20:0] phys_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    seg_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
        .seg_wr_data(seg_wr_data), .offset(offset), .acc_kind(acc_kind),
        .use_extra(use_extra), .io_wr_stb(io_wr_stb), .io_wr_data(io_wr_data),
        .phys_addr(phys_addr)
    );

    // Expected address from the requirements
    function automatic logic [20:0] model(input logic [15:0] s, input logic [15:0] o,
                                          input logic g);
        logic [20:0] sum;
        sum = ({5'd0, s} << 4) + {5'd0, o};
        if (!g) sum[20] = 1'b0;
        return sum;
    endfunction

    task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
        end
    endtask

    task automatic load_seg(input logic [1:0] sel, input logic [15:0] v);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = v;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    task automatic port_write(input logic [7:0] v);
        @(negedge clk);
        io_wr_stb = 1'b1; io_wr_data = v;
        @(negedge clk);
        io_wr_stb = 1'b0;
    endtask

    task automatic probe(input logic [1:0] kind, input logic ovr, input logic [15:0] off);
        @(negedge clk);
        acc_kind = kind; use_extra = ovr; offset = off;
        #2;
    endtask

    task automatic t_reset;
        probe(2'd0, 1'b0, 16'h1234);
        check("R1 fetch after reset", phys_addr, 21'h01234);
        probe(2'd2, 1'b1, 16'hFFFF);
        check("R1 extra after reset", phys_addr, 21'h0FFFF);
    endtask

    task automatic t_select;
        load_seg(2'd0, 16'h1000);
        load_seg(2'd1, 16'h2000);
        load_seg(2'd2, 16'h3000);
        load_seg(2'd3, 16'h4000);
        probe(2'd0, 1'b0, 16'h0010);
        check("R3 fetch uses code", phys_addr, model(16'h1000, 16'h0010, 1'b0));
        probe(2'd1, 1'b0, 16'h0010);
        check("R4 data uses data", phys_addr, model(16'h2000, 16'h0010, 1'b0));
        probe(2'd3, 1'b0, 16'h0010);
        check("R4 kind 3 uses data", phys_addr, model(16'h2000, 16'h0010, 1'b0));
        probe(2'd2, 1'b0, 16'h0010);
        check("R5 stack uses stack", phys_addr, model(16'h3000, 16'h0010, 1'b0));
        for (int k = 0; k < 4; k++) begin
            probe(k[1:0], 1'b1, 16'h0010);
            check("R6 override uses extra", phys_addr, model(16'h4000, 16'h0010, 1'b0));
        end
        load_seg(2'd1, 16'h2A00);
        probe(2'd1, 1'b0, 16'h0003);
        check("R2 data reloaded", phys_addr, model(16'h2A00, 16'h0003, 1'b0));
        probe(2'd0, 1'b0, 16'h0003);
        check("R2 code kept", phys_addr, model(16'h1000, 16'h0003, 1'b0));
        probe(2'd2, 1'b0, 16'h0003);
        check("R2 stack kept", phys_addr, model(16'h3000, 16'h0003, 1'b0));
    endtask

    task automatic t_gate;
        load_seg(2'd0, 16'hFFFF);
        probe(2'd0, 1'b0, 16'hFFFF);
        check("R8 closed wraps FFFF:FFFF", phys_addr, 21'h00FFEF);
        port_write(8'h02);
        probe(2'd0, 1'b0, 16'hFFFF);
        check("R7 open FFFF:FFFF", phys_addr, 21'h10FFEF);
        check("R9 bit1 opens", phys_addr[20], 1'b1);
        port_write(8'hFD);
        probe(2'd0, 1'b0, 16'hFFFF);
        check("R9 other bits ignored", phys_addr, 21'h00FFEF);
        port_write(8'hFF);
        @(negedge clk);
        io_wr_data = 8'h00;
        repeat (3) @(negedge clk);
        #2;
        check("R10 no strobe holds", phys_addr, 21'h10FFEF);
        load_seg(2'd2, 16'hF800);
        probe(2'd2, 1'b0, 16'h8000);
        check("R7 carry into bit 20", phys_addr, 21'h100000);
        port_write(8'h00);
        probe(2'd2, 1'b0, 16'h8000);
        check("R8 carry dropped", phys_addr, 21'h000000);
        probe(2'd1, 1'b0, 16'h0010);
        check("R8 low sum untouched", phys_addr, model(16'h2A00, 16'h0010, 1'b0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_gate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule